// File: doc/BRIEF.md
# DMA Thread Fault Handling Controller

This block keeps the run state of one manager thread and a set of channel threads of a DMA engine, and handles what happens when one of them aborts. Instruction execution, the bus master and the instruction cache sit outside. The block sees them only through start and abort events, per-channel counts of bus transactions still outstanding, and the enable, invalidate and flush signals it drives back.

An aborting channel does not fault at once. It first enters a draining state. In that state it stops executing, its cache entries are invalidated and its queued but unissued bus requests are discarded. Transactions that are already in flight are allowed to finish, and the channel moves to the faulted state only after its outstanding count reaches zero. An aborting manager goes straight to the faulted state. The abort interrupt stays high while any thread is draining or faulted. Per-thread status shows which threads are faulted and a one-hot cause.

Recovery is done through a small debug port. An agent first writes an instruction word and a target thread, then writes a command. If the instruction is the kill opcode and the target is faulted, the target returns to Stopped. Writes aimed at a secure thread must come through the secure access path, or they are dropped. A command aimed at a thread that is not faulted is dropped and sets a sticky error flag.

Top module: `dma_fault_ctrl`

## Requirements
- R1: After reset every thread is Stopped (state code 0), the interrupt and the debug error flag are low, all stored causes and program counters are zero, and no channel execute enable is high.
- R2: A Stopped thread that gets its start pulse is Running (state code 1) from the next cycle. A channel then has its execute enable high and captures its non-secure bit from the start input.
- R3: A channel abort (valid, with a channel index) that hits a Running channel moves that channel to Draining (state code 2) on the next cycle and drops its execute enable. An abort that hits a channel that is not Running has no effect.
- R4: The cache-invalidate and queue-flush outputs of a channel are high for exactly the first cycle the channel spends in Draining.
- R5: On an accepted channel abort, the channel's program counter output takes the abort address only when the precise flag is high. Otherwise it keeps its previous value.
- R6: A Draining channel stays Draining while its outstanding transaction count is nonzero. It becomes Faulted (state code 3) on the cycle after the first edge at which the count is zero.
- R7: A manager abort while the manager is Running moves the manager directly to Faulted on the next cycle.
- R8: A thread's fault flag is high exactly when it is Faulted. Its cause register holds the one-hot cause given with the abort and is cleared when the thread returns to Stopped.
- R9: The abort interrupt is high exactly while at least one thread is Draining or Faulted.
- R10: A command write returns the stored target to Stopped on the next cycle when the target is Faulted and the stored instruction equals the kill opcode (parameter, default 8'h01). A command with any other stored opcode has no effect.
- R11: When the target thread is secure, instruction and command writes made with the secure-access input low are dropped. The manager's security comes from a static input. A channel's security is its captured non-secure bit, and a Stopped channel counts as secure.
- R12: An accepted command write whose stored target is not Faulted changes no state and sets the debug error flag, which then stays high until reset.
- R13: A channel's non-secure output shows its captured bit while the channel is not Stopped, and reads 0 while it is Stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mgr_ns_i | input | 1 | Manager thread is non-secure (static) |
| mgr_start_i | input | 1 | Start pulse for the manager |
| mgr_abort_i | input | 1 | Manager abort event |
| mgr_cause_i | input | CAUSE_W | One-hot manager abort cause |
| ch_start_i | input | NUM_CH | Per-channel start pulse |
| ch_start_ns_i | input | NUM_CH | Non-secure bit captured at channel start |
| ch_abort_i | input | 1 | Channel abort event |
| ch_abort_id_i | input | CH_IDX_W | Index of the aborting channel |
| ch_abort_cause_i | input | CAUSE_W | One-hot channel abort cause |
| ch_abort_precise_i | input | 1 | Abort address is exact |
| ch_abort_pc_i | input | PC_W | Address of the aborted instruction |
| ch_otx_i | input | NUM_CH*OTX_W | Outstanding bus transaction count per channel |
| dbg_secure_i | input | 1 | Debug write arrives on the secure path |
| dbg_insn_wr_i | input | 1 | Write the debug instruction and target |
| dbg_insn_i | input | INSN_W | Debug instruction opcode |
| dbg_tgt_mgr_i | input | 1 | Target is the manager thread |
| dbg_tgt_ch_i | input | CH_IDX_W | Target channel index |
| dbg_cmd_wr_i | input | 1 | Debug command write |
| irq_abort_o | output | 1 | Abort interrupt |
| mgr_state_o | output | 2 | Manager state code |
| mgr_fault_o | output | 1 | Manager is Faulted |
| mgr_cause_o | output | CAUSE_W | Manager fault cause |
| ch_state_o | output | NUM_CH*2 | Channel state codes |
| ch_fault_o | output | NUM_CH | Channel is Faulted |
| ch_cause_o | output | NUM_CH*CAUSE_W | Channel fault causes |
| ch_pc_o | output | NUM_CH*PC_W | Channel program counters |
| ch_exec_en_o | output | NUM_CH | Channel may execute instructions |
| ch_ns_o | output | NUM_CH | Channel non-secure bit (0 when Stopped) |
| ch_inv_o | output | NUM_CH | Cache invalidate strobe |
| ch_qflush_o | output | NUM_CH | Read/write queue flush strobe |
| dbg_err_o | output | 1 | Sticky debug error flag |

## Verification
The bench builds the block with its defaults: four channels, 4-bit outstanding counts, 32-bit addresses, 4-bit causes and an 8-bit opcode with kill at 8'h01. Four channels are enough to hold one secure channel, one non-secure channel, one channel left Running and one left Stopped, alongside the manager. This lets the security gate, a command to a non-faulted target, an abort to a Stopped channel and the interrupt OR all be exercised in one run. The 4-bit count lets a channel be held in Draining over several cycles with a nonzero count before it is released.

// File: rtl/dma_fault_pkg.sv
package dma_fault_pkg;
  typedef enum logic [1:0] {
    THR_STOPPED  = 2'd0,
    THR_RUNNING  = 2'd1,
    THR_DRAINING = 2'd2,
    THR_FAULTED  = 2'd3
  } thr_state_e;
endpackage

// File: rtl/dma_chan_thread.sv
module dma_chan_thread
  import dma_fault_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int OTX_W   = 4,
  parameter int CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               start_ns_i,
  input  logic               abort_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               precise_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [OTX_W-1:0]   otx_i,
  input  logic               kill_i,
  output thr_state_e         state_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    pc_o,
  output logic               ns_o,
  output logic               exec_en_o,
  output logic               inv_o,
  output logic               qflush_o
);
  thr_state_e         state_q, state_d;
  logic [CAUSE_W-1:0] cause_q;
  logic [PC_W-1:0]    pc_q;
  logic               ns_q, pulse_q;
  logic               take_abort, take_kill;

  assign take_abort = (state_q == THR_RUNNING) && abort_i;
  assign take_kill  = (state_q == THR_FAULTED) && kill_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      THR_STOPPED:  if (start_i) state_d = THR_RUNNING;
      THR_RUNNING:  if (abort_i) state_d = THR_DRAINING;
      // wait for in-flight bus transfers before faulting
      THR_DRAINING: if (otx_i == '0) state_d = THR_FAULTED;
      THR_FAULTED:  if (kill_i) state_d = THR_STOPPED;
      default:      state_d = THR_STOPPED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= THR_STOPPED;
      cause_q <= '0;
      pc_q    <= '0;
      ns_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= take_abort;
      if ((state_q == THR_STOPPED) && start_i) ns_q <= start_ns_i;
      if (take_abort) begin
        cause_q <= cause_i;
        if (precise_i) pc_q <= pc_i;
      end else if (take_kill) begin
        cause_q <= '0;
      end
    end
  end

  assign state_o   = state_q;
  assign cause_o   = cause_q;
  assign pc_o      = pc_q;
  assign ns_o      = ns_q && (state_q != THR_STOPPED);
  assign exec_en_o = (state_q == THR_RUNNING);
  assign inv_o     = pulse_q;
  assign qflush_o  = pulse_q;
endmodule

// File: rtl/dma_dbg_gate.sv
module dma_dbg_gate #(
  parameter int              NUM_CH   = 4,
  parameter int              CH_IDX_W = 2,
  parameter int              INSN_W   = 8,
  parameter logic [INSN_W-1:0] KILL_OP = 8'h01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                secure_i,
  input  logic                insn_wr_i,
  input  logic [INSN_W-1:0]   insn_i,
  input  logic                tgt_mgr_i,
  input  logic [CH_IDX_W-1:0] tgt_ch_i,
  input  logic                cmd_wr_i,
  input  logic                mgr_ns_i,
  input  logic                mgr_fault_i,
  input  logic [NUM_CH-1:0]   ch_ns_i,
  input  logic [NUM_CH-1:0]   ch_fault_i,
  output logic                kill_mgr_o,
  output logic [NUM_CH-1:0]   kill_ch_o,
  output logic                err_o
);
  logic [INSN_W-1:0]   op_q;
  logic                tgt_mgr_q, err_q;
  logic [CH_IDX_W-1:0] tgt_ch_q;
  logic                new_ns, cur_ns, cur_fault;
  logic                insn_ok, cmd_ok, do_kill;

  always_comb begin
    new_ns    = 1'b0;
    cur_ns    = 1'b0;
    cur_fault = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (tgt_ch_i == CH_IDX_W'(i)) new_ns = ch_ns_i[i];
      if (tgt_ch_q == CH_IDX_W'(i)) begin
        cur_ns    = ch_ns_i[i];
        cur_fault = ch_fault_i[i];
      end
    end
    if (tgt_mgr_i) new_ns = mgr_ns_i;
    if (tgt_mgr_q) begin
      cur_ns    = mgr_ns_i;
      cur_fault = mgr_fault_i;
    end
  end

  // secure targets accept only secure-path writes
  assign insn_ok = insn_wr_i && (secure_i || new_ns);
  assign cmd_ok  = cmd_wr_i && (secure_i || cur_ns);
  assign do_kill = cmd_ok && cur_fault && (op_q == KILL_OP);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      kill_ch_o[i] = do_kill && !tgt_mgr_q && (tgt_ch_q == CH_IDX_W'(i));
  end
  assign kill_mgr_o = do_kill && tgt_mgr_q;
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= '0;
      tgt_mgr_q <= 1'b0;
      tgt_ch_q  <= '0;
      err_q     <= 1'b0;
    end else begin
      if (insn_ok) begin
        op_q      <= insn_i;
        tgt_mgr_q <= tgt_mgr_i;
        tgt_ch_q  <= tgt_ch_i;
      end
      if (cmd_ok && !cur_fault) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_fault_ctrl.sv
module dma_fault_ctrl
  import dma_fault_pkg::*;
#(
  parameter int                NUM_CH  = 4,
  parameter int                PC_W    = 32,
  parameter int                OTX_W   = 4,
  parameter int                CAUSE_W = 4,
  parameter int                INSN_W  = 8,
  parameter logic [INSN_W-1:0] KILL_OP = 8'h01,
  localparam int               CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mgr_ns_i,
  input  logic                      mgr_start_i,
  input  logic                      mgr_abort_i,
  input  logic [CAUSE_W-1:0]        mgr_cause_i,
  input  logic [NUM_CH-1:0]         ch_start_i,
  input  logic [NUM_CH-1:0]         ch_start_ns_i,
  input  logic                      ch_abort_i,
  input  logic [CH_IDX_W-1:0]       ch_abort_id_i,
  input  logic [CAUSE_W-1:0]        ch_abort_cause_i,
  input  logic                      ch_abort_precise_i,
  input  logic [PC_W-1:0]           ch_abort_pc_i,
  input  logic [NUM_CH*OTX_W-1:0]   ch_otx_i,
  input  logic                      dbg_secure_i,
  input  logic                      dbg_insn_wr_i,
  input  logic [INSN_W-1:0]         dbg_insn_i,
  input  logic                      dbg_tgt_mgr_i,
  input  logic [CH_IDX_W-1:0]       dbg_tgt_ch_i,
  input  logic                      dbg_cmd_wr_i,
  output logic                      irq_abort_o,
  output logic [1:0]                mgr_state_o,
  output logic                      mgr_fault_o,
  output logic [CAUSE_W-1:0]        mgr_cause_o,
  output logic [NUM_CH*2-1:0]       ch_state_o,
  output logic [NUM_CH-1:0]         ch_fault_o,
  output logic [NUM_CH*CAUSE_W-1:0] ch_cause_o,
  output logic [NUM_CH*PC_W-1:0]    ch_pc_o,
  output logic [NUM_CH-1:0]         ch_exec_en_o,
  output logic [NUM_CH-1:0]         ch_ns_o,
  output logic [NUM_CH-1:0]         ch_inv_o,
  output logic [NUM_CH-1:0]         ch_qflush_o,
  output logic                      dbg_err_o
);
  thr_state_e         mgr_state_q;
  logic [CAUSE_W-1:0] mgr_cause_q;
  logic               kill_mgr;
  logic [NUM_CH-1:0]  kill_ch, ch_busy;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    thr_state_e st;
    logic       hit;
    assign hit = ch_abort_i && (ch_abort_id_i == CH_IDX_W'(i));

    dma_chan_thread #(
      .PC_W(PC_W), .OTX_W(OTX_W), .CAUSE_W(CAUSE_W)
    ) u_thr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (ch_start_i[i]),
      .start_ns_i (ch_start_ns_i[i]),
      .abort_i    (hit),
      .cause_i    (ch_abort_cause_i),
      .precise_i  (ch_abort_precise_i),
      .pc_i       (ch_abort_pc_i),
      .otx_i      (ch_otx_i[i*OTX_W +: OTX_W]),
      .kill_i     (kill_ch[i]),
      .state_o    (st),
      .cause_o    (ch_cause_o[i*CAUSE_W +: CAUSE_W]),
      .pc_o       (ch_pc_o[i*PC_W +: PC_W]),
      .ns_o       (ch_ns_o[i]),
      .exec_en_o  (ch_exec_en_o[i]),
      .inv_o      (ch_inv_o[i]),
      .qflush_o   (ch_qflush_o[i])
    );

    assign ch_state_o[i*2 +: 2] = st;
    assign ch_fault_o[i]        = (st == THR_FAULTED);
    assign ch_busy[i]           = (st == THR_DRAINING) || (st == THR_FAULTED);
  end

  // manager faults without a drain phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mgr_state_q <= THR_STOPPED;
      mgr_cause_q <= '0;
    end else begin
      case (mgr_state_q)
        THR_STOPPED: if (mgr_start_i) mgr_state_q <= THR_RUNNING;
        THR_RUNNING: if (mgr_abort_i) begin
          mgr_state_q <= THR_FAULTED;
          mgr_cause_q <= mgr_cause_i;
        end
        THR_FAULTED: if (kill_mgr) begin
          mgr_state_q <= THR_STOPPED;
          mgr_cause_q <= '0;
        end
        default: mgr_state_q <= THR_STOPPED;
      endcase
    end
  end

  dma_dbg_gate #(
    .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W), .INSN_W(INSN_W), .KILL_OP(KILL_OP)
  ) u_dbg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .secure_i    (dbg_secure_i),
    .insn_wr_i   (dbg_insn_wr_i),
    .insn_i      (dbg_insn_i),
    .tgt_mgr_i   (dbg_tgt_mgr_i),
    .tgt_ch_i    (dbg_tgt_ch_i),
    .cmd_wr_i    (dbg_cmd_wr_i),
    .mgr_ns_i    (mgr_ns_i),
    .mgr_fault_i (mgr_fault_o),
    .ch_ns_i     (ch_ns_o),
    .ch_fault_i  (ch_fault_o),
    .kill_mgr_o  (kill_mgr),
    .kill_ch_o   (kill_ch),
    .err_o       (dbg_err_o)
  );

  assign mgr_state_o = mgr_state_q;
  assign mgr_fault_o = (mgr_state_q == THR_FAULTED);
  assign mgr_cause_o = mgr_cause_q;
  assign irq_abort_o = mgr_fault_o || (|ch_busy);
endmodule

// File: rtl/dma_fault_ctrl_chk.sv
module dma_fault_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int PC_W   = 32,
  parameter int OTX_W  = 4,
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ch_abort_i,
  input logic [CH_IDX_W-1:0]     ch_abort_id_i,
  input logic                    ch_abort_precise_i,
  input logic [NUM_CH*OTX_W-1:0] ch_otx_i,
  input logic                    mgr_abort_i,
  input logic [1:0]              mgr_state_o,
  input logic [NUM_CH*2-1:0]     ch_state_o,
  input logic [NUM_CH*PC_W-1:0]  ch_pc_o,
  input logic [NUM_CH-1:0]       ch_inv_o,
  input logic                    irq_abort_o,
  input logic                    dbg_err_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    logic hit;
    assign hit = ch_abort_i && (ch_abort_id_i == CH_IDX_W'(i));

    // R3
    abort_to_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && ch_state_o[i*2 +: 2] == 2'd1) |=> (ch_state_o[i*2 +: 2] == 2'd2));
    // R4
    inv_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_inv_o[i] |=> !ch_inv_o[i]);
    // R5
    imprecise_pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && !ch_abort_precise_i) |=> $stable(ch_pc_o[i*PC_W +: PC_W]));
    // R6
    drain_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_state_o[i*2 +: 2] == 2'd2 && ch_otx_i[i*OTX_W +: OTX_W] != '0)
      |=> (ch_state_o[i*2 +: 2] == 2'd2));
  end

  // R7
  mgr_direct_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgr_abort_i && mgr_state_o == 2'd1) |=> (mgr_state_o == 2'd3));
  // R9
  mgr_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgr_state_o == 2'd3) |-> irq_abort_o);
  // R12
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_err_o |=> dbg_err_o);
endmodule

bind dma_fault_ctrl dma_fault_ctrl_chk #(
  .NUM_CH(NUM_CH), .PC_W(PC_W), .OTX_W(OTX_W)
) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .ch_abort_i         (ch_abort_i),
  .ch_abort_id_i      (ch_abort_id_i),
  .ch_abort_precise_i (ch_abort_precise_i),
  .ch_otx_i           (ch_otx_i),
  .mgr_abort_i        (mgr_abort_i),
  .mgr_state_o        (mgr_state_o),
  .ch_state_o         (ch_state_o),
  .ch_pc_o            (ch_pc_o),
  .ch_inv_o           (ch_inv_o),
  .irq_abort_o        (irq_abort_o),
  .dbg_err_o          (dbg_err_o)
);

// File: tb/dma_fault_ctrl_test.sv
module dma_fault_ctrl_test;
  localparam int NUM_CH = 4, PC_W = 32, OTX_W = 4, CAUSE_W = 4, INSN_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mgr_ns_i, mgr_start_i, mgr_abort_i;
  logic [CAUSE_W-1:0] mgr_cause_i, ch_abort_cause_i;
  logic [NUM_CH-1:0] ch_start_i, ch_start_ns_i;
  logic ch_abort_i, ch_abort_precise_i;
  logic [1:0] ch_abort_id_i, dbg_tgt_ch_i;
  logic [PC_W-1:0] ch_abort_pc_i;
  logic [NUM_CH*OTX_W-1:0] ch_otx_i;
  logic dbg_secure_i, dbg_insn_wr_i, dbg_tgt_mgr_i, dbg_cmd_wr_i;
  logic [INSN_W-1:0] dbg_insn_i;
  logic irq_abort_o, mgr_fault_o, dbg_err_o;
  logic [1:0] mgr_state_o;
  logic [CAUSE_W-1:0] mgr_cause_o;
  logic [NUM_CH*2-1:0] ch_state_o;
  logic [NUM_CH-1:0] ch_fault_o, ch_exec_en_o, ch_ns_o, ch_inv_o, ch_qflush_o;
  logic [NUM_CH*CAUSE_W-1:0] ch_cause_o;
  logic [NUM_CH*PC_W-1:0] ch_pc_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4ns clk_i = ~clk_i;

  dma_fault_ctrl uut (.*);

  task automatic step();
    @(posedge clk_i);
    #1ns;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] st(input int i);
    return ch_state_o[i*2 +: 2];
  endfunction

  task automatic dbg_insn(input logic sec, input logic [7:0] op, input logic mgr, input logic [1:0] ch);
    dbg_secure_i = sec; dbg_insn_wr_i = 1'b1; dbg_insn_i = op;
    dbg_tgt_mgr_i = mgr; dbg_tgt_ch_i = ch;
    step();
    dbg_insn_wr_i = 1'b0;
  endtask

  task automatic dbg_cmd(input logic sec);
    dbg_secure_i = sec; dbg_cmd_wr_i = 1'b1;
    step();
    dbg_cmd_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ch state", 64'(ch_state_o), 64'h0);
    chk("R1 mgr state", 64'(mgr_state_o), 64'h0);
    chk("R1 irq", 64'(irq_abort_o), 64'h0);
    chk("R1 err", 64'(dbg_err_o), 64'h0);
    chk("R1 causes", 64'(ch_cause_o), 64'h0);
    chk("R1 pc", 64'(ch_pc_o[63:0]), 64'h0);
    chk("R1 exec", 64'(ch_exec_en_o), 64'h0);
  endtask

  task automatic t_start();
    ch_start_i = 4'b0111; ch_start_ns_i = 4'b0101; mgr_start_i = 1'b1;
    step();
    ch_start_i = '0; mgr_start_i = 1'b0;
    chk("R2 ch state", 64'(ch_state_o), 64'h15);
    chk("R2 exec", 64'(ch_exec_en_o), 64'h7);
    chk("R13 ns running", 64'(ch_ns_o), 64'h5);
    chk("R2 mgr", 64'(mgr_state_o), 64'h1);
    chk("R9 irq idle", 64'(irq_abort_o), 64'h0);
  endtask

  task automatic t_stopped_abort();
    ch_abort_i = 1'b1; ch_abort_id_i = 2'd3; ch_abort_cause_i = 4'b0001;
    step();
    ch_abort_i = 1'b0;
    chk("R3 stopped ignore", 64'(st(3)), 64'h0);
    chk("R9 no irq", 64'(irq_abort_o), 64'h0);
  endtask

  task automatic t_abort_precise();
    ch_otx_i[3:0] = 4'd2;
    ch_abort_i = 1'b1; ch_abort_id_i = 2'd0; ch_abort_precise_i = 1'b1;
    ch_abort_pc_i = 32'h1000_0040; ch_abort_cause_i = 4'b0010;
    step();
    ch_abort_i = 1'b0;
    chk("R3 drain", 64'(st(0)), 64'h2);
    chk("R3 exec off", 64'(ch_exec_en_o[0]), 64'h0);
    chk("R9 irq drain", 64'(irq_abort_o), 64'h1);
    chk("R4 inv", 64'(ch_inv_o), 64'h1);
    chk("R4 qflush", 64'(ch_qflush_o), 64'h1);
    chk("R5 precise pc", 64'(ch_pc_o[31:0]), 64'h1000_0040);
    chk("R8 cause", 64'(ch_cause_o[3:0]), 64'h2);
    chk("R8 not faulted yet", 64'(ch_fault_o[0]), 64'h0);
    step();
    chk("R6 still drain", 64'(st(0)), 64'h2);
    chk("R4 inv one cycle", 64'(ch_inv_o[0]), 64'h0);
    ch_otx_i[3:0] = 4'd0;
    step();
    chk("R6 faulted", 64'(st(0)), 64'h3);
    chk("R8 fault flag", 64'(ch_fault_o[0]), 64'h1);
  endtask

  task automatic t_abort_imprecise();
    ch_abort_i = 1'b1; ch_abort_id_i = 2'd1; ch_abort_precise_i = 1'b0;
    ch_abort_pc_i = 32'hDEAD_BEEF; ch_abort_cause_i = 4'b1000;
    step();
    ch_abort_i = 1'b0;
    chk("R5 imprecise pc", 64'(ch_pc_o[63:32]), 64'h0);
    chk("R3 drain ch1", 64'(st(1)), 64'h2);
    step();
    chk("R6 zero count", 64'(st(1)), 64'h3);
    chk("R8 fault vec", 64'(ch_fault_o), 64'h3);
  endtask

  task automatic t_mgr_abort();
    mgr_abort_i = 1'b1; mgr_cause_i = 4'b0100;
    step();
    mgr_abort_i = 1'b0;
    chk("R7 mgr faulted", 64'(mgr_state_o), 64'h3);
    chk("R8 mgr flag", 64'(mgr_fault_o), 64'h1);
    chk("R8 mgr cause", 64'(mgr_cause_o), 64'h4);
  endtask

  task automatic t_kill_ns();
    dbg_insn(1'b0, 8'h01, 1'b0, 2'd0);
    dbg_cmd(1'b0);
    chk("R10 kill ch0", 64'(st(0)), 64'h0);
    chk("R8 cause clear", 64'(ch_cause_o[3:0]), 64'h0);
    chk("R8 flag clear", 64'(ch_fault_o[0]), 64'h0);
    chk("R13 ns stopped", 64'(ch_ns_o), 64'h4);
  endtask

  task automatic t_secure_gate();
    dbg_insn(1'b0, 8'h01, 1'b0, 2'd1);
    dbg_cmd(1'b0);
    chk("R11 ns write dropped", 64'(st(1)), 64'h3);
    chk("R11 no err", 64'(dbg_err_o), 64'h0);
    dbg_insn(1'b1, 8'h01, 1'b0, 2'd1);
    dbg_cmd(1'b1);
    chk("R11 secure kill", 64'(st(1)), 64'h0);
  endtask

  task automatic t_wrong_op();
    dbg_insn(1'b1, 8'h22, 1'b1, 2'd0);
    dbg_cmd(1'b1);
    chk("R10 other op", 64'(mgr_state_o), 64'h3);
    chk("R10 other op err", 64'(dbg_err_o), 64'h0);
    dbg_insn(1'b0, 8'h01, 1'b1, 2'd0);
    dbg_cmd(1'b0);
    chk("R10 kill mgr", 64'(mgr_state_o), 64'h0);
    chk("R8 mgr cause clear", 64'(mgr_cause_o), 64'h0);
    chk("R9 irq clear", 64'(irq_abort_o), 64'h0);
  endtask

  task automatic t_dbg_err();
    dbg_insn(1'b1, 8'h01, 1'b0, 2'd2);
    dbg_cmd(1'b1);
    chk("R12 running kept", 64'(st(2)), 64'h1);
    chk("R12 err set", 64'(dbg_err_o), 64'h1);
    step();
    chk("R12 err sticky", 64'(dbg_err_o), 64'h1);
  endtask

  initial begin
    mgr_ns_i = 1'b1; mgr_start_i = 1'b0; mgr_abort_i = 1'b0; mgr_cause_i = '0;
    ch_start_i = '0; ch_start_ns_i = '0; ch_abort_i = 1'b0; ch_abort_id_i = '0;
    ch_abort_cause_i = '0; ch_abort_precise_i = 1'b0; ch_abort_pc_i = '0; ch_otx_i = '0;
    dbg_secure_i = 1'b0; dbg_insn_wr_i = 1'b0; dbg_insn_i = '0;
    dbg_tgt_mgr_i = 1'b0; dbg_tgt_ch_i = '0; dbg_cmd_wr_i = 1'b0;
    step();
    step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_start();
    t_stopped_abort();
    t_abort_precise();
    t_abort_imprecise();
    t_mgr_abort();
    t_kill_ns();
    t_secure_gate();
    t_wrong_op();
    t_dbg_err();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800us;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule